// File: doc/BRIEF.md
# Zero-Substituting Bipolar Line Encoder

This block turns a serial binary stream into a three-level bipolar symbol stream with one symbol for each accepted bit. Two output rails carry the symbol. A positive pulse sets `pos_o`, a negative pulse sets `neg_o`, and a space leaves both rails low. Ones become pulses whose polarity alternates. Long runs of zeros are replaced by a fixed-length pattern. That pattern ends in a deliberate polarity violation, so the line always carries enough transitions for clock recovery at the far end.

A mode input selects the run length that triggers a substitution. Mode 0 selects four zeros, replaced by 000V or B00V. Mode 1 selects three zeros, replaced by 00V or B0V. The choice of pattern depends on a running parity: the number of non-violation pulses sent since the last violation must be odd when the next violation goes out. This makes successive violations alternate in polarity, so the line keeps no DC offset. The encoder has to see a whole run before it can emit the run's first symbol, so every bit passes through a short delay line. Each symbol appears a fixed number of accepted bits after the bit it encodes.

Top module: `zs_bipolar_enc`

## Requirements
- R1: An input 1 that is not part of a substitution is sent as a pulse whose polarity is opposite to the previous pulse on the line, and an input 0 outside a substituted run is sent as a space (both rails low).
- R2: With `mode_i` = 0, every run of four zeros is sent as 000V or B00V. V is a pulse with the same polarity as the pulse before it, and B is a pulse that obeys alternation. `mode_i` is held steady whenever reset is released.
- R3: With `mode_i` = 1, every run of three zeros is sent as 00V or B0V, with B and V as in R2.
- R4: The leading B is inserted exactly when the count of non-violation pulses (marks and B pulses) since the last V, or since reset, is even. Consecutive V pulses therefore have opposite polarity.
- R5: After reset, both rails and `sym_vld_o` are low, the last pulse counts as negative, and the pulse count counts as even. A stream that starts with a zero run therefore begins with a positive B.
- R6: With `bit_vld_i` held high, the symbol for a bit sampled at one rising edge appears at the outputs after the L-th following edge, where L = 4 in mode 0 and L = 3 in mode 1. The first L accepted bits after reset produce no symbol, and the latency is the same whether or not a substitution occurs.
- R7: In a cycle after an edge at which `bit_vld_i` was low, `sym_vld_o`, `pos_o` and `neg_o` are all low, and the delay line holds its contents.
- R8: `pos_o` and `neg_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld_i | input | 1 | Input bit is valid in this cycle |
| bit_i | input | 1 | Serial data bit |
| mode_i | input | 1 | 0: four-zero substitution, 1: three-zero substitution |
| pos_o | output | 1 | Positive pulse rail |
| neg_o | output | 1 | Negative pulse rail |
| sym_vld_o | output | 1 | A symbol is present on the rails |

## Verification
The mark just before a zero run leaves the delay line at the very edge where the run is recognised and its leading slot is tagged as B or space. That mark's effect on the pulse parity must therefore reach the B decision within the same cycle, and the bench provokes this with streams such as 1-0000 and 11-000. Back-to-back runs place a V leaving the parity tracker next to a fresh run decision, and pseudo-random zero-heavy streams, with and without gaps in the valid input, make these collisions common. An independent sequential model predicts every symbol, and a queue-based monitor compares each emitted symbol against its prediction, naming the requirement that decided it.

// File: rtl/zs_pkg.sv
package zs_pkg;

  typedef enum logic [2:0] {
    SYM_IDLE   = 3'd0,
    SYM_SPACE  = 3'd1,
    SYM_MARK   = 3'd2,
    SYM_BPULSE = 3'd3,
    SYM_VPULSE = 3'd4
  } sym_t;

  // parity flag update: marks and B pulses toggle, V restarts at even
  function automatic logic even_after(input logic even_q, input sym_t s);
    case (s)
      SYM_MARK, SYM_BPULSE: even_after = ~even_q;
      SYM_VPULSE:           even_after = 1'b1;
      default:              even_after = even_q;
    endcase
  endfunction

  // rail pair {pos, neg} for a symbol given the polarity of the last pulse
  function automatic logic [1:0] rails_for(input sym_t s, input logic last_pos);
    case (s)
      SYM_MARK, SYM_BPULSE: rails_for = {~last_pos, last_pos};
      SYM_VPULSE:           rails_for = {last_pos, ~last_pos};
      default:              rails_for = 2'b00;
    endcase
  endfunction

  function automatic logic is_pulse(input sym_t s);
    is_pulse = (s == SYM_MARK) || (s == SYM_BPULSE) || (s == SYM_VPULSE);
  endfunction

endpackage

// File: rtl/zs_window.sv
module zs_window
  import zs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             bit_i,
  input  logic [LEN_W-1:0] run_len_i,
  input  logic             even_i,
  output sym_t             tap_o,
  output logic             run_hit_o
);

  sym_t stage_q [DEPTH];
  sym_t stage_d [DEPTH];
  logic all_space;

  // zero-run detection over the youngest run_len-1 entries plus the new bit
  always_comb begin
    all_space = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (i < int'(run_len_i) - 1 && stage_q[i] != SYM_SPACE) all_space = 1'b0;
    end
  end

  assign run_hit_o = step_i & ~bit_i & all_space;

  always_comb begin
    tap_o = SYM_IDLE;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == int'(run_len_i) - 1) tap_o = stage_q[i];
    end
  end

  always_comb begin
    stage_d[0] = bit_i ? SYM_MARK : SYM_SPACE;
    if (run_hit_o) stage_d[0] = SYM_VPULSE;
    for (int i = 1; i < DEPTH; i++) begin
      stage_d[i] = stage_q[i-1];
      if (run_hit_o && i == int'(run_len_i) - 1)
        stage_d[i] = even_i ? SYM_BPULSE : SYM_SPACE;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    sym_t q;
    always_ff @(posedge clk) begin
      if (!rst_n)      q <= SYM_IDLE;
      else if (step_i) q <= stage_d[g];
    end
    assign stage_q[g] = q;
  end

  // R2
  tag_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit_o |=> stage_q[0] == SYM_VPULSE);

endmodule

// File: rtl/zs_emitter.sv
module zs_emitter
  import zs_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  sym_t             tap_i,
  input  logic [LEN_W-1:0] run_len_i,
  output logic             even_next_o,
  output logic             pos_o,
  output logic             neg_o,
  output logic             sym_vld_o
);

  logic       last_pos_q;
  logic       even_q;
  logic       v_out_q;
  logic [1:0] rails;

  assign even_next_o = even_after(even_q, tap_i);
  assign rails       = rails_for(tap_i, last_pos_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      even_q     <= 1'b1;
      pos_o      <= 1'b0;
      neg_o      <= 1'b0;
      sym_vld_o  <= 1'b0;
      v_out_q    <= 1'b0;
    end else if (step_i) begin
      pos_o     <= rails[1];
      neg_o     <= rails[0];
      sym_vld_o <= (tap_i != SYM_IDLE);
      v_out_q   <= (tap_i == SYM_VPULSE);
      even_q    <= even_next_o;
      if (is_pulse(tap_i)) last_pos_q <= rails[1];
    end else begin
      pos_o     <= 1'b0;
      neg_o     <= 1'b0;
      sym_vld_o <= 1'b0;
      v_out_q   <= 1'b0;
    end
  end

  // observation state for the line-level properties
  logic             prev_v_pos_q;
  logic             v_seen_q;
  logic             odd_pulses_q;
  logic [LEN_W-1:0] space_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v_pos_q <= 1'b0;
      v_seen_q     <= 1'b0;
      odd_pulses_q <= 1'b0;
      space_run_q  <= '0;
    end else begin
      if (v_out_q) begin
        prev_v_pos_q <= pos_o;
        v_seen_q     <= 1'b1;
        odd_pulses_q <= 1'b0;
      end else if (pos_o || neg_o) begin
        odd_pulses_q <= ~odd_pulses_q;
      end
      if (sym_vld_o) begin
        if (pos_o || neg_o) space_run_q <= '0;
        else                space_run_q <= space_run_q + 1'b1;
      end
    end
  end

  // R8
  rails_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_o && neg_o));

  // R4
  v_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_out_q |-> odd_pulses_q);

  // R4
  v_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_out_q && v_seen_q) |-> (pos_o != prev_v_pos_q));

  // R3
  space_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld_o && !pos_o && !neg_o) |-> (space_run_q < run_len_i - 1'b1));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> (!sym_vld_o && !pos_o && !neg_o));

endmodule

// File: rtl/zs_bipolar_enc.sv
module zs_bipolar_enc
  import zs_pkg::*;
#(
  parameter int HI_RUN = 4,
  parameter int LO_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic mode_i,
  output logic pos_o,
  output logic neg_o,
  output logic sym_vld_o
);

  localparam int DEPTH = (HI_RUN > LO_RUN) ? HI_RUN : LO_RUN;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic [LEN_W-1:0] run_len;
  sym_t             tap;
  logic             even_next;
  logic             run_hit;

  assign run_len = mode_i ? LEN_W'(LO_RUN) : LEN_W'(HI_RUN);

  zs_window #(.DEPTH(DEPTH), .LEN_W(LEN_W)) i_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (bit_vld_i),
    .bit_i     (bit_i),
    .run_len_i (run_len),
    .even_i    (even_next),
    .tap_o     (tap),
    .run_hit_o (run_hit)
  );

  zs_emitter #(.LEN_W(LEN_W)) i_emitter (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (bit_vld_i),
    .tap_i       (tap),
    .run_len_i   (run_len),
    .even_next_o (even_next),
    .pos_o       (pos_o),
    .neg_o       (neg_o),
    .sym_vld_o   (sym_vld_o)
  );

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_i));

endmodule

// File: tb/test_zs_bipolar_enc.sv
module test_zs_bipolar_enc;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld_i = 1'b0;
  logic bit_i = 1'b0;
  logic mode_i = 1'b0;
  logic pos_o, neg_o, sym_vld_o;

  always #2ns clk = ~clk;

  zs_bipolar_enc i_zs_bipolar_enc (
    .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .mode_i(mode_i), .pos_o(pos_o), .neg_o(neg_o), .sym_vld_o(sym_vld_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // reference model state
  int    exp_q[$];
  string tag_q[$];
  int    m_last, m_cnt, m_pend, m_len;
  int    beats, pops, first_vld_cyc, drive0_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // sequential model of the line code
  task automatic model_bit(input bit b);
    string rt = (m_len == 4) ? "R2" : "R3";
    if (b) begin
      for (int i = 0; i < m_pend; i++) push(0, "R1");
      m_pend = 0;
      m_last = -m_last;
      push(m_last, "R1");
      m_cnt++;
    end else begin
      m_pend++;
      if (m_pend == m_len) begin
        if (m_cnt % 2 == 0) begin
          m_last = -m_last;
          push(m_last, "R4");
          m_cnt++;
          for (int i = 0; i < m_len - 2; i++) push(0, rt);
        end else begin
          for (int i = 0; i < m_len - 1; i++) push(0, rt);
        end
        push(m_last, rt);
        m_cnt  = 0;
        m_pend = 0;
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sym_vld_o) begin
      int act, e;
      string t;
      act = pos_o ? 1 : (neg_o ? -1 : 0);
      if (first_vld_cyc < 0) first_vld_cyc = cyc;
      pops++;
      check(!(pos_o && neg_o), "R8", {30'd0, pos_o, neg_o}, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", act, 99);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act == e, t, act, e);
      end
    end
  end

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0;
    bit_vld_i = 1'b0;
    mode_i = m;
    repeat (3) @(negedge clk);
    check(!pos_o && !neg_o && !sym_vld_o, "R5", {29'd0, pos_o, neg_o, sym_vld_o}, 0);
    exp_q.delete();
    tag_q.delete();
    m_last = -1; m_cnt = 0; m_pend = 0;
    m_len = m ? 3 : 4;
    beats = 0; pops = 0; first_vld_cyc = -1;
    rst_n = 1'b1;
  endtask

  task automatic beat(input bit b);
    @(negedge clk);
    if (beats == 0) drive0_cyc = cyc;
    bit_vld_i = 1'b1;
    bit_i = b;
    beats++;
    model_bit(b);
  endtask

  task automatic gap();
    @(negedge clk);
    bit_vld_i = 1'b0;
    bit_i = 1'b1;
    @(negedge clk);
    check(!sym_vld_o && !pos_o && !neg_o, "R7", {29'd0, pos_o, neg_o, sym_vld_o}, 0);
  endtask

  task automatic finish_run();
    @(negedge clk);
    bit_vld_i = 1'b0;
    repeat (3) @(negedge clk);
    check(pops == beats - m_len, "R6", pops, beats - m_len);
  endtask

  task automatic send(input string s);
    for (int i = 0; i < s.len(); i++) beat(s[i] == "1");
  endtask

  initial begin
    #(4ns * 150000);
    check(1'b0, "watchdog", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lf;
    // R5 / R2: all-zero start, B00V alternating
    do_reset(1'b0);
    send("0000000000000000");
    check(first_vld_cyc - drive0_cyc - 1 == 4, "R6", first_vld_cyc - drive0_cyc - 1, 4);
    finish_run();

    // R2 / R4: mark right before runs, back-to-back runs
    do_reset(1'b0);
    send("10000110000000010001100001000011");
    finish_run();

    // R3 / R4 in three-zero mode
    do_reset(1'b1);
    send("000000100011000000101000100");
    check(first_vld_cyc - drive0_cyc - 1 == 3, "R6", first_vld_cyc - drive0_cyc - 1, 3);
    finish_run();

    // R7: gaps in the valid input, mode 0
    do_reset(1'b0);
    send("10"); gap(); send("00"); gap(); send("0011"); gap(); gap(); send("000010");
    finish_run();

    // R7: gaps, mode 1
    do_reset(1'b1);
    send("1"); gap(); send("000"); gap(); send("0100");
    finish_run();

    // zero-heavy pseudo-random streams in both modes
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      lf = 32'h1d3a5;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        if (lf[7:5] == 3'd0) gap();
        beat(lf[0] & lf[3]);
      end
      finish_run();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule